// File: doc/BRIEF.md
# Channel Interrupt Enable/Status Word

This block keeps the interrupt state for a group of timer channels in one 32-bit register word. The low field holds one enable bit per channel and the field above it holds one pending flag per channel. Software reads the whole word and writes it in one access. Each write replaces the enable field, and writing a one to a pending flag clears that flag.

Each channel's counter sends a one-cycle expiry pulse. The pulse sets that channel's pending flag whether or not the channel is enabled. The block drives one interrupt line per channel. A line goes high only at the cycle of an expiry, and only when the channel is enabled in that cycle. It goes low only when a write clears the channel's pending flag. Changing an enable bit at any other time leaves the line alone, so the line acts like a captured edge, not a level derived from the enable and the flag.

The read word is a plain combinational view of the stored state. A write or an expiry presented in one cycle shows up on the read word and on the interrupt lines just after the next rising clock edge.

Top module: `irq_flag_word`

## Requirements
- R1: With CHANNELS channels, bits [CHANNELS-1:0] of the word are the enables, with channel n at bit n. The pending flag for channel n is at bit CHANNELS+n. With the default of 5 channels, the enables are bits [4:0] and the flags are bits [9:5].
- R2: An expiry pulse on a channel sets that channel's pending flag at the next clock edge, whether the channel is enabled or not.
- R3: A channel's interrupt line rises at the clock edge after an expiry only if the channel's enable bit is set in the cycle of the expiry. The enable value used is the stored one, before any write in that same cycle.
- R4: On a write, the enable field takes the written bits directly. A written 1 in a pending-flag position clears that flag, and a written 0 leaves it unchanged.
- R5: A channel's interrupt line falls at the clock edge where a write clears its pending flag. At no other time does it fall.
- R6: After reset, the whole word reads 0 and every interrupt line is low.
- R7: Clearing an enable bit does not lower a line that is already high. Setting an enable bit while the flag is already pending does not raise the line.
- R8: If an expiry and a clearing write reach the same pending flag in the same cycle, the expiry wins. The flag stays set and the line is not lowered.
- R9: Bits [31:2*CHANNELS] always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset that clears all state |
| wr_en | input | 1 | Register write strobe for this cycle |
| wr_data | input | 32 | Value written: new enables in the low field, ones to clear flags in the next field |
| rd_data | output | 32 | Current word: enables, pending flags, upper bits zero |
| expiry | input | CHANNELS | One-cycle expiry pulse per channel |
| irq | output | CHANNELS | Interrupt line per channel |

## Verification
The bench builds the block with its default of five channels. This makes the top channel, bit 4 with its flag at bit 9, the last position before the reserved zero bits, so every lane and the boundary into the unused bits is reachable. Directed tasks drive each channel individually and all channels at once. They also cover the cases where the enables are changed while a line is high or a flag is pending, and where an expiry and a clearing write land on the same flag in the same cycle.

// File: rtl/irq_flag_word.sv
module irq_flag_word #(
  parameter int CHANNELS = 5,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_data,
  output logic [WORD_W-1:0]   rd_data,
  input  logic [CHANNELS-1:0] expiry,
  output logic [CHANNELS-1:0] irq
);
  localparam int USED_W = 2 * CHANNELS;
  localparam int SPARE_W = WORD_W - USED_W;

  logic [CHANNELS-1:0] en_q, pend_q, irq_q;
  logic [CHANNELS-1:0] clr_req, clr_eff, raise;

  assign clr_req = wr_en ? wr_data[USED_W-1:CHANNELS] : '0;
  assign clr_eff = clr_req & ~expiry;
  assign raise   = expiry & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_q  <= '0;
    end else begin
      if (wr_en) en_q <= wr_data[CHANNELS-1:0];
      pend_q <= (pend_q & ~clr_req) | expiry;
      irq_q  <= (irq_q & ~clr_eff) | raise;
    end
  end

  assign rd_data = {{SPARE_W{1'b0}}, pend_q, en_q};
  assign irq     = irq_q;

  // R2
  expiry_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|expiry) |=> ((rd_data[USED_W-1:CHANNELS] & $past(expiry)) == $past(expiry)));

  // R3
  rise_needs_enabled_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~$past(irq) & ~$past(expiry & rd_data[CHANNELS-1:0])) == '0));

  // R5
  fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~irq & $past(irq) & ~$past(clr_req)) == '0));

  // R4
  enable_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[CHANNELS-1:0] == $past(wr_data[CHANNELS-1:0])));

  // R8
  expiry_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(expiry & clr_req)) |=> ((irq & $past(irq & expiry & clr_req)) == $past(irq & expiry & clr_req)));

  // R5
  line_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~rd_data[USED_W-1:CHANNELS]) == '0));
endmodule

// File: tb/test_irq_flag_word.sv
module test_irq_flag_word;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [N-1:0] expiry = '0;
  logic [N-1:0] irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  irq_flag_word #(.CHANNELS(N), .WORD_W(32)) i_irq_flag_word (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .expiry(expiry), .irq(irq)
  );

  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit w, logic [31:0] d, logic [N-1:0] e);
    @(negedge clk);
    wr_en = w; wr_data = d; expiry = e;
    @(posedge clk);
    #1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; expiry = '0;
    #1;
  endtask

  task automatic t_reset();
    check("R6 word", rd_data, 32'h0);
    check("R6 irq", {27'b0, irq}, 32'h0);
  endtask

  task automatic t_enables();
    cyc(1, 32'h15, '0);
    check("R1 R4 enable field", rd_data, 32'h15);
    cyc(1, 32'hFFFF_FC00, '0);
    check("R9 upper bits ignored", rd_data, 32'h0);
  endtask

  task automatic t_expiry();
    cyc(1, 32'h01, '0);
    cyc(0, '0, 5'b00001);
    check("R2 flag ch0", rd_data, 32'h21);
    check("R3 irq ch0", {27'b0, irq}, 32'h01);
    cyc(0, '0, 5'b00010);
    check("R2 flag ch1 disabled", rd_data, 32'h61);
    check("R3 no irq ch1", {27'b0, irq}, 32'h01);
  endtask

  task automatic t_clear();
    cyc(1, 32'h21, '0);
    check("R4 clear ch0", rd_data, 32'h41);
    check("R5 irq ch0 low", {27'b0, irq}, 32'h0);
    cyc(1, 32'h00, '0);
    check("R4 zero keeps flag", rd_data, 32'h40);
  endtask

  task automatic t_enable_quirks();
    cyc(1, 32'h02, '0);
    check("R7 late enable no raise", {27'b0, irq}, 32'h0);
    check("R7 word", rd_data, 32'h42);
    cyc(1, 32'h04, '0);
    cyc(0, '0, 5'b00100);
    check("R3 irq ch2", {27'b0, irq}, 32'h04);
    check("R2 flags", rd_data, 32'hC4);
    cyc(1, 32'h00, '0);
    check("R7 disable keeps line", {27'b0, irq}, 32'h04);
    check("R7 word", rd_data, 32'hC0);
  endtask

  task automatic t_collision();
    cyc(1, 32'h80, 5'b00100);
    check("R8 flag survives", rd_data, 32'hC0);
    check("R8 line stays", {27'b0, irq}, 32'h04);
    cyc(1, 32'h80, '0);
    check("R5 clear ch2", rd_data, 32'h40);
    check("R5 irq ch2 low", {27'b0, irq}, 32'h0);
    cyc(1, 32'h40, '0);
    check("R4 clear ch1", rd_data, 32'h0);
  endtask

  task automatic t_edges();
    cyc(1, 32'h10, '0);
    cyc(0, '0, 5'b10000);
    check("R1 top flag bit9", rd_data, 32'h210);
    check("R3 irq ch4", {27'b0, irq}, 32'h10);
    cyc(1, 32'h210, '0);
    check("R5 clear ch4", {27'b0, irq}, 32'h0);
    cyc(1, 32'h1F, '0);
    cyc(0, '0, 5'b11111);
    check("R2 all flags", rd_data, 32'h3FF);
    check("R3 all lines", {27'b0, irq}, 32'h1F);
    cyc(1, 32'hFFFF_FFE0, '0);
    check("R4 R9 clear all", rd_data, 32'h0);
    check("R5 all low", {27'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_enables();
    t_expiry();
    t_clear();
    t_enable_quirks();
    t_collision();
    t_edges();
    done = 1'b1;
  end

  initial begin
    int cnt = 0;
    while (!done && cnt < 20000) begin
      @(posedge clk);
      cnt++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule